// File: doc/BRIEF.md
# Multi-mode serial port

This block is a serial port for an 8-bit controller. It has one asynchronous transmit engine, one asynchronous receive engine and one synchronous shift engine. A two-bit mode input selects which of four framings is active. In the synchronous mode the port moves exactly eight bits, least significant bit first, over a single bidirectional data pin. The other pin drives the shift clock, which runs at a fixed division of the system clock. The three asynchronous modes use a start bit, eight data bits, an optional ninth bit and a stop bit. The bit time comes either from a fixed division of the system clock or from an external timer overflow tick.

Software drives the port through level and strobe inputs. Writing a byte starts a transmission. Separate strobes clear the sticky transmit flag, receive flag and framing error flag. The ninth bit to send is taken from a control input when the write is accepted. A received ninth bit, or in the ten-bit mode the received stop bit, is presented on its own output. A global clock enable freezes every timing counter while it is low.

Top module: `sport_top`

## Requirements
- R1: After a cycle with `rst` high, `txd_o` is 1, `rxd_oe` is 0, `tx_flag`, `rx_flag` and `frm_err` are 0, `rd_data` is 0 and `rb8_out` is 0.
- R2: In mode 0 (`mode`=0) a write sends the 8 bits of `wr_data` LSB first on `rxd_o` with `rxd_oe`=1. Each bit lasts SYNC_DIV clocks. For that bit, `txd_o` is 0 during the first SYNC_DIV/2 clocks and 1 during the rest, and `rxd_o` changes only while `txd_o` is 0.
- R3: In mode 0 a reception starts when `rx_en` is 1 and `rx_flag` is 0. It drives the same shift clock on `txd_o` and samples `rxd_i` on each rising half of that clock, filling LSB first. After 8 bits, `rx_flag` sets and the byte appears on `rd_data`. No reception starts while `rx_flag` is 1.
- R4: Mode 1 sends 10 bits on `txd_o` starting the cycle after the write: a 0 start bit, 8 data bits LSB first, then a 1 stop bit. The base tick is `tmr_tick`, and a bit lasts 16 base ticks when `dbl_rate`=1 or 32 when `dbl_rate`=0. The line is 1 when idle.
- R5: Modes 2 and 3 send 11 bits: a start bit, 8 data bits, a ninth bit equal to `tb8_in` at the time of the write, then a stop bit. Mode 3 times its bits like mode 1.
- R6: In mode 2 every enabled clock is a base tick, so a bit lasts 16 clocks when `dbl_rate`=1 and 32 clocks when it is 0.
- R7: `tx_flag` sets in the same cycle the stop bit appears on `txd_o` (in mode 0, when the eighth bit ends). It stays set until a `clr_tx` pulse. A set in the same cycle as a clear wins.
- R8: The asynchronous receiver votes on three samples around the middle of each bit and takes the majority. At the stop bit's vote it sets `rx_flag` and loads `rd_data`. `rb8_out` takes the stop bit in mode 1 and the ninth bit in modes 2 and 3. A one-clock glitch inside a bit does not alter the result.
- R9: A start bit that votes 1 at its middle is discarded: no flag is set and `rd_data` is kept.
- R10: A stop bit that votes 0 sets `frm_err` together with `rx_flag`. `frm_err` stays set through later good frames until a `clr_err` pulse.
- R11: In modes 1 to 3, while `rx_en` is 0, a frame on `rxd_i` sets no flag and leaves `rd_data` unchanged.
- R12: While `clk_en` is 0 all bit timing stops and `txd_o` holds its value.
- R13: A write made while an asynchronous frame is being sent is ignored, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Global clock enable for all timing |
| tmr_tick | input | 1 | External timer overflow pulse, the base tick in modes 1 and 3 |
| mode | input | 2 | Framing select 0 to 3 |
| rx_en | input | 1 | Receive enable |
| dbl_rate | input | 1 | Halves the bit time in modes 1 to 3 |
| tb8_in | input | 1 | Ninth bit to transmit in modes 2 and 3 |
| wr_en | input | 1 | Write strobe that starts a transmission |
| wr_data | input | 8 | Byte to transmit |
| clr_tx | input | 1 | Clears the transmit flag |
| clr_rx | input | 1 | Clears the receive flag |
| clr_err | input | 1 | Clears the framing error flag |
| rxd_i | input | 1 | Receive data pin input |
| rd_data | output | 8 | Last received byte |
| rb8_out | output | 1 | Received ninth bit or stop bit |
| tx_flag | output | 1 | Transmit done flag |
| rx_flag | output | 1 | Receive done flag |
| frm_err | output | 1 | Framing error flag |
| txd_o | output | 1 | Async serial output, or shift clock in mode 0 |
| rxd_o | output | 1 | Data pin output in mode 0 |
| rxd_oe | output | 1 | Data pin drive enable in mode 0 |

## Verification
A wrong bit counter or shift register in the transmitter shows on `txd_o` within one bit time, and a wrong flag shows within one bit time as well. The bench replays every transmit frame in a behavioural queue model and compares the line and `tx_flag` on every clock. A wrong receive counter or a wrong sample position shows only at the end of a frame, as a wrong `rd_data`, `rb8_out` or flag value. For that reason the receive cases include a mid-bit glitch, a false start and a bad stop bit. A broken synchronous engine shows on the clock and data pins within the first bit of a transfer.

// File: rtl/sport_pkg.sv
package sport_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 3;   // start, data, ninth, stop

    typedef enum logic [1:0] {
        MODE_SHIFT   = 2'd0,
        MODE_A10     = 2'd1,
        MODE_A11_FIX = 2'd2,
        MODE_A11_VAR = 2'd3
    } sport_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              ferr;
    } rx_result_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic has_ninth(input sport_mode_e m);
        return (m == MODE_A11_FIX) || (m == MODE_A11_VAR);
    endfunction
endpackage

// File: rtl/sport_async_tx.sv
module sport_async_tx
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              dbl,
    input  logic              load,
    input  logic              ninth_en,
    input  logic              ninth,
    input  logic [DATA_W-1:0] data,
    output logic              line,
    output logic              stop_start
);
    localparam int CNT_W = $clog2(2 * OVS);
    localparam int IDX_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx, last;
    logic               active;

    logic [CNT_W-1:0] bit_end;
    logic             bit_done;

    assign bit_end    = dbl ? CNT_W'(OVS - 1) : CNT_W'(2 * OVS - 1);
    assign bit_done   = active && base_tick && (cnt == bit_end);
    assign stop_start = bit_done && ((idx + IDX_W'(1)) == last);
    assign line       = active ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '1;
            cnt    <= '0;
            idx    <= '0;
            last   <= '0;
        end else if (!active) begin
            if (load) begin
                active <= 1'b1;
                cnt    <= '0;
                idx    <= '0;
                sh     <= ninth_en ? {1'b1, ninth, data, 1'b0} : {2'b11, data, 1'b0};
                last   <= ninth_en ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
            end
        end else if (base_tick) begin
            if (cnt == bit_end) begin
                cnt <= '0;
                sh  <= {1'b1, sh[FRAME_W-1:1]};
                idx <= idx + IDX_W'(1);
                if (idx == last) active <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sport_async_rx.sv
module sport_async_rx
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       base_tick,
    input  logic       dbl,
    input  logic       ninth_en,
    input  logic       arm,
    input  logic       line_in,
    output logic       done,
    output rx_result_t result
);
    localparam int CNT_W = $clog2(2 * OVS);
    localparam int IDX_W = $clog2(FRAME_W + 1);

    logic              prev, active, s_a, s_b, nine;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;

    logic [CNT_W-1:0] bit_end, mid, step;
    logic [IDX_W-1:0] stop_idx;
    logic             vote, decide;

    assign bit_end  = dbl ? CNT_W'(OVS - 1) : CNT_W'(2 * OVS - 1);
    assign mid      = dbl ? CNT_W'(OVS / 2 - 1) : CNT_W'(OVS - 1);
    assign step     = dbl ? CNT_W'(1) : CNT_W'(2);
    assign stop_idx = ninth_en ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
    assign vote     = vote3(s_a, s_b, line_in);
    assign decide   = active && base_tick && (cnt == mid + step);
    assign done     = decide && (idx == stop_idx);

    assign result.data = sh;
    assign result.bit9 = ninth_en ? nine : vote;
    assign result.ferr = !vote;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b1;
            active <= 1'b0;
            s_a    <= 1'b1;
            s_b    <= 1'b1;
            nine   <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
            sh     <= '0;
        end else begin
            prev <= line_in;
            if (!active) begin
                if (arm && prev && !line_in) begin
                    active <= 1'b1;
                    cnt    <= '0;
                    idx    <= '0;
                end
            end else if (base_tick) begin
                if (cnt == mid - step) s_a <= line_in;
                if (cnt == mid)        s_b <= line_in;
                if (decide) begin
                    if (idx == '0) begin
                        if (vote) active <= 1'b0;
                    end else if (idx == stop_idx) begin
                        active <= 1'b0;
                    end else if (idx == IDX_W'(DATA_W + 1)) begin
                        nine <= vote;
                    end else begin
                        sh <= {vote, sh[DATA_W-1:1]};
                    end
                end
                if (cnt == bit_end) begin
                    cnt <= '0;
                    idx <= idx + IDX_W'(1);
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/sport_sync.sv
module sport_sync
    import sport_pkg::*;
#(
    parameter int DIV = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              start_tx,
    input  logic              start_rx,
    input  logic [DATA_W-1:0] data_in,
    input  logic              din,
    output logic              sclk,
    output logic              dout,
    output logic              oe,
    output logic              busy,
    output logic              tx_done,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int HALF = DIV / 2;
    localparam int CNT_W = $clog2(DIV);
    localparam int NB_W  = $clog2(DATA_W);

    logic              active, is_rx;
    logic [CNT_W-1:0]  cnt;
    logic [NB_W-1:0]   nbit;
    logic [DATA_W-1:0] sh;
    logic              last;

    assign last    = active && en && (cnt == CNT_W'(DIV - 1)) && (nbit == NB_W'(DATA_W - 1));
    assign tx_done = last && !is_rx;
    assign rx_done = last && is_rx;
    assign rx_data = sh;
    assign sclk    = active ? (cnt >= CNT_W'(HALF)) : 1'b1;
    assign dout    = sh[0];
    assign oe      = active && !is_rx;
    assign busy    = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            is_rx  <= 1'b0;
            cnt    <= '0;
            nbit   <= '0;
            sh     <= '0;
        end else if (!active) begin
            if (en && (start_tx || start_rx)) begin
                active <= 1'b1;
                is_rx  <= !start_tx;
                cnt    <= '0;
                nbit   <= '0;
                if (start_tx) sh <= data_in;
            end
        end else if (en) begin
            if (is_rx && cnt == CNT_W'(HALF)) sh <= {din, sh[DATA_W-1:1]};
            if (cnt == CNT_W'(DIV - 1)) begin
                cnt  <= '0;
                nbit <= nbit + NB_W'(1);
                if (!is_rx) sh <= {1'b0, sh[DATA_W-1:1]};
                if (nbit == NB_W'(DATA_W - 1)) active <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int SYNC_DIV = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       tmr_tick,
    input  logic [1:0] mode,
    input  logic       rx_en,
    input  logic       dbl_rate,
    input  logic       tb8_in,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       clr_tx,
    input  logic       clr_rx,
    input  logic       clr_err,
    input  logic       rxd_i,
    output logic [7:0] rd_data,
    output logic       rb8_out,
    output logic       tx_flag,
    output logic       rx_flag,
    output logic       frm_err,
    output logic       txd_o,
    output logic       rxd_o,
    output logic       rxd_oe
);
    sport_mode_e md;
    logic        is_sync, ninth_en, base_tick;
    logic [1:0]  rx_meta;

    assign md        = sport_mode_e'(mode);
    assign is_sync   = (md == MODE_SHIFT);
    assign ninth_en  = has_ninth(md);
    assign base_tick = clk_en && ((md == MODE_A11_FIX) || tmr_tick);

    always_ff @(posedge clk) begin
        if (rst) rx_meta <= 2'b11;
        else     rx_meta <= {rx_meta[0], rxd_i};
    end

    logic a_line, a_stop_start;
    sport_async_tx #(.OVS(OVS)) u_atx (
        .clk(clk), .rst(rst), .base_tick(base_tick), .dbl(dbl_rate),
        .load(wr_en && !is_sync), .ninth_en(ninth_en), .ninth(tb8_in),
        .data(wr_data), .line(a_line), .stop_start(a_stop_start)
    );

    logic       a_done;
    rx_result_t a_res;
    sport_async_rx #(.OVS(OVS)) u_arx (
        .clk(clk), .rst(rst), .base_tick(base_tick), .dbl(dbl_rate),
        .ninth_en(ninth_en), .arm(rx_en && !is_sync && clk_en),
        .line_in(rx_meta[1]), .done(a_done), .result(a_res)
    );

    logic              s_clk, s_busy, s_tx_done, s_rx_done;
    logic [DATA_W-1:0] s_rx_data;
    sport_sync #(.DIV(SYNC_DIV)) u_sync (
        .clk(clk), .rst(rst), .en(clk_en),
        .start_tx(is_sync && wr_en), .start_rx(is_sync && rx_en && !rx_flag),
        .data_in(wr_data), .din(rxd_i), .sclk(s_clk), .dout(rxd_o),
        .oe(rxd_oe), .busy(s_busy), .tx_done(s_tx_done), .rx_done(s_rx_done),
        .rx_data(s_rx_data)
    );

    assign txd_o = s_busy ? s_clk : a_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_flag <= 1'b0;
            rx_flag <= 1'b0;
            frm_err <= 1'b0;
            rd_data <= '0;
            rb8_out <= 1'b0;
        end else begin
            if (a_stop_start || s_tx_done) tx_flag <= 1'b1;
            else if (clr_tx)               tx_flag <= 1'b0;

            if (a_done || s_rx_done) rx_flag <= 1'b1;
            else if (clr_rx)         rx_flag <= 1'b0;

            if (a_done && a_res.ferr) frm_err <= 1'b1;
            else if (clr_err)         frm_err <= 1'b0;

            if (a_done) begin
                rd_data <= a_res.data;
                rb8_out <= a_res.bit9;
            end else if (s_rx_done) begin
                rd_data <= s_rx_data;
            end
        end
    end
endmodule

// File: rtl/sport_chk.sv
module sport_chk (
    input logic       clk,
    input logic       rst,
    input logic       clk_en,
    input logic       wr_en,
    input logic       clr_tx,
    input logic       clr_err,
    input logic       tx_flag,
    input logic       rx_flag,
    input logic       frm_err,
    input logic       txd_o,
    input logic       rxd_o,
    input logic       rxd_oe
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_flag && !rx_flag && !frm_err && txd_o && !rxd_oe));

    // R2
    shift_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rxd_oe && txd_o) |-> $stable(rxd_o));

    // R7
    tx_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_flag && !clr_tx) |=> tx_flag);

    // R10
    frm_err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_err && !clr_err) |=> frm_err);

    // R10
    frm_err_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_err) |-> rx_flag);

    // R12
    freeze_line_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !wr_en) |=> $stable(txd_o));
endmodule

bind sport_top sport_chk u_sport_chk (
    .clk(clk), .rst(rst), .clk_en(clk_en), .wr_en(wr_en), .clr_tx(clr_tx),
    .clr_err(clr_err), .tx_flag(tx_flag), .rx_flag(rx_flag), .frm_err(frm_err),
    .txd_o(txd_o), .rxd_o(rxd_o), .rxd_oe(rxd_oe)
);

// File: tb/test_sport_top.sv
module test_sport_top;
    localparam int OVS  = 16;
    localparam int DIV  = 12;
    localparam int TPER = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_en = 1'b1, tmr_tick = 1'b0, rx_en = 1'b0, dbl_rate = 1'b0, tb8_in = 1'b0;
    logic wr_en = 1'b0, clr_tx = 1'b0, clr_rx = 1'b0, clr_err = 1'b0, rxd_i = 1'b1;
    logic [1:0] mode = 2'd2;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic rb8_out, tx_flag, rx_flag, frm_err, txd_o, rxd_o, rxd_oe;

    always #2 clk = ~clk;

    sport_top #(.OVS(OVS), .SYNC_DIV(DIV)) i_sport_top (
        .clk(clk), .rst(rst), .clk_en(clk_en), .tmr_tick(tmr_tick), .mode(mode),
        .rx_en(rx_en), .dbl_rate(dbl_rate), .tb8_in(tb8_in), .wr_en(wr_en),
        .wr_data(wr_data), .clr_tx(clr_tx), .clr_rx(clr_rx), .clr_err(clr_err),
        .rxd_i(rxd_i), .rd_data(rd_data), .rb8_out(rb8_out), .tx_flag(tx_flag),
        .rx_flag(rx_flag), .frm_err(frm_err), .txd_o(txd_o), .rxd_o(rxd_o),
        .rxd_oe(rxd_oe)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // timer overflow source
    int tcnt = 0;
    always @(negedge clk) begin
        if (tcnt == TPER - 1) begin tcnt <= 0; tmr_tick <= 1'b1; end
        else begin tcnt <= tcnt + 1; tmr_tick <= 1'b0; end
    end

    // behavioural reference for the asynchronous transmit line and flag
    bit q[$];
    int mcnt = 0;
    bit exp_tf = 0;
    bit cmp_on = 0;
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            mcnt = 0;
            exp_tf = 0;
        end else begin
            bit base, tf_set;
            int blen;
            base   = clk_en && (mode == 2'd2 || tmr_tick);
            blen   = dbl_rate ? OVS : 2 * OVS;
            tf_set = 0;
            if (q.size() == 0) begin
                if (wr_en && mode != 2'd0) begin
                    mcnt = 0;
                    q.push_back(1'b0);
                    for (int i = 0; i < 8; i++) q.push_back(wr_data[i]);
                    if (mode[1]) q.push_back(tb8_in);
                    q.push_back(1'b1);
                end
            end else if (base) begin
                if (mcnt == blen - 1) begin
                    mcnt = 0;
                    void'(q.pop_front());
                    if (q.size() == 1) tf_set = 1;
                end else begin
                    mcnt++;
                end
            end
            if (tf_set) exp_tf = 1;
            else if (clr_tx) exp_tf = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_on) begin
            chk("R4/R5 async line", txd_o, (q.size() != 0) ? q[0] : 1'b1);
            chk("R7 tx_flag", tx_flag, exp_tf);
        end
    end

    task automatic pulse_clear();
        clr_tx = 1; clr_rx = 1; clr_err = 1;
        @(negedge clk);
        clr_tx = 0; clr_rx = 0; clr_err = 0;
    endtask

    task automatic write_byte(input logic [7:0] d, input logic b9);
        wr_data = d; tb8_in = b9; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic send_rx(input logic [7:0] d, input bit nine_en, input logic b9,
                           input logic stopv, input int bitcyc, input int gidx);
        bit fr[$];
        fr.push_back(1'b0);
        for (int i = 0; i < 8; i++) fr.push_back(d[i]);
        if (nine_en) fr.push_back(b9);
        fr.push_back(stopv);
        for (int b = 0; b < fr.size(); b++)
            for (int i = 0; i < bitcyc; i++) begin
                rxd_i = (b == gidx && i == bitcyc / 2) ? ~fr[b] : fr[b];
                @(negedge clk);
            end
        rxd_i = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int n;
        bit bad;
        logic held;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd_o, 1'b1);
        chk("R1 oe", rxd_oe, 1'b0);
        chk("R1 flags", {tx_flag, rx_flag, frm_err}, 3'b000);
        chk("R1 rd_data/rb8", {rd_data, rb8_out}, 9'h0);
        rst = 0;
        @(negedge clk);
        cmp_on = 1;

        // R6 mode 2, doubled rate: start bit is 16 clocks
        mode = 2'd2; dbl_rate = 1;
        write_byte(8'hA5, 1'b1);
        n = 0;
        while (txd_o == 1'b0) begin n++; @(negedge clk); end
        chk("R6 start bit clocks dbl", n, 16);
        repeat (11 * 16 + 10) @(negedge clk);
        chk("R7 tx_flag after mode2 frame", tx_flag, 1'b1);
        pulse_clear();

        // R6 mode 2 normal rate: start + two zero data bits = 96 clocks
        dbl_rate = 0;
        write_byte(8'h3C, 1'b0);
        n = 0;
        while (txd_o == 1'b0) begin n++; @(negedge clk); end
        chk("R6 low run clocks normal", n, 96);
        repeat (11 * 32 + 10) @(negedge clk);
        pulse_clear();

        // R4 mode 1 on timer ticks, R13 write while busy
        mode = 2'd1; dbl_rate = 1;
        write_byte(8'h5A, 1'b0);
        repeat (200) @(negedge clk);
        write_byte(8'hFF, 1'b1);
        repeat (10 * 16 * TPER) @(negedge clk);
        chk("R4 tx_flag mode1", tx_flag, 1'b1);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            if (txd_o !== 1'b1) bad = 1;
            @(negedge clk);
        end
        chk("R13 no second frame", bad, 1'b0);
        pulse_clear();

        // R5 mode 3 with ninth bit, R12 freeze mid-frame
        mode = 2'd3; dbl_rate = 0;
        write_byte(8'h81, 1'b1);
        repeat (150) @(negedge clk);
        clk_en = 0;
        held = txd_o;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (txd_o !== held) bad = 1;
            @(negedge clk);
        end
        clk_en = 1;
        chk("R12 line frozen", bad, 1'b0);
        repeat (11 * 32 * TPER + 40) @(negedge clk);
        chk("R5 tx_flag mode3", tx_flag, 1'b1);
        pulse_clear();

        // R8 receive mode 2 doubled rate
        rx_en = 1; mode = 2'd2; dbl_rate = 1;
        send_rx(8'hC3, 1, 1'b1, 1'b1, 16, -1);
        chk("R8 rx_flag m2", rx_flag, 1'b1);
        chk("R8 rd_data m2", rd_data, 8'hC3);
        chk("R8 rb8 ninth m2", rb8_out, 1'b1);
        chk("R10 no ferr good frame", frm_err, 1'b0);
        pulse_clear();

        // R8 receive mode 1: rb8 holds stop bit
        mode = 2'd1;
        send_rx(8'h2D, 0, 1'b0, 1'b1, 16 * TPER, -1);
        chk("R8 rx_flag m1", rx_flag, 1'b1);
        chk("R8 rd_data m1", rd_data, 8'h2D);
        chk("R8 rb8 stop m1", rb8_out, 1'b1);
        pulse_clear();

        // R8 majority vote rejects a one-clock glitch in data bit 3
        mode = 2'd2; dbl_rate = 0;
        send_rx(8'h6E, 1, 1'b0, 1'b1, 32, 4);
        chk("R8 glitch rd_data", rd_data, 8'h6E);
        chk("R8 glitch rb8", rb8_out, 1'b0);
        pulse_clear();

        // R9 false start
        dbl_rate = 1;
        rxd_i = 0;
        repeat (3) @(negedge clk);
        rxd_i = 1;
        repeat (300) @(negedge clk);
        chk("R9 no flag on false start", rx_flag, 1'b0);
        chk("R9 rd_data kept", rd_data, 8'h6E);

        // R10 framing error, sticky
        send_rx(8'h11, 1, 1'b0, 1'b0, 16, -1);
        chk("R10 ferr set", frm_err, 1'b1);
        chk("R10 rx_flag with ferr", rx_flag, 1'b1);
        clr_rx = 1; @(negedge clk); clr_rx = 0;
        send_rx(8'h22, 1, 1'b1, 1'b1, 16, -1);
        chk("R10 ferr sticky", frm_err, 1'b1);
        chk("R8 rd_data after error", rd_data, 8'h22);
        clr_err = 1; @(negedge clk); clr_err = 0;
        chk("R10 ferr cleared", frm_err, 1'b0);
        pulse_clear();

        // R11 receive disabled
        rx_en = 0;
        send_rx(8'h99, 1, 1'b1, 1'b1, 16, -1);
        chk("R11 no flag", rx_flag, 1'b0);
        chk("R11 rd_data kept", rd_data, 8'h22);

        // R2 mode 0 transmit
        cmp_on = 0;
        pulse_clear();
        mode = 2'd0;
        write_byte(8'h96, 1'b0);
        for (int k = 0; k < 8; k++) begin
            bad = 0;
            for (int c = 0; c < DIV; c++) begin
                if (txd_o !== (c >= DIV / 2)) bad = 1;
                if (rxd_o !== ((8'h96 >> k) & 1)) bad = 1;
                if (rxd_oe !== 1'b1) bad = 1;
                @(negedge clk);
            end
            chk($sformatf("R2 shift out bit %0d", k), bad, 1'b0);
        end
        chk("R2 idle after 8 bits", {rxd_oe, txd_o}, 2'b01);
        chk("R7 tx_flag mode0", tx_flag, 1'b1);
        pulse_clear();

        // R3 mode 0 receive
        rx_en = 1; rxd_i = 1'b1;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < 8; k++)
            for (int c = 0; c < DIV; c++) begin
                rxd_i = (8'h4B >> k) & 1;
                if (txd_o !== (c >= DIV / 2)) bad = 1;
                @(negedge clk);
            end
        chk("R3 shift clock on txd", bad, 1'b0);
        chk("R3 rx_flag mode0", rx_flag, 1'b1);
        chk("R3 rd_data mode0", rd_data, 8'h4B);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (txd_o !== 1'b1) bad = 1;
            @(negedge clk);
        end
        chk("R3 no restart while flag set", bad, 1'b0);
        rx_en = 0;
        pulse_clear();

        finish_run();
    end
endmodule